// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Global Enable

This block sits beside a small 8-bit processor core. It decides when the core should enter an interrupt handler and which vector index to use. It accepts two groups of sources. Event sources are latched into sticky flags. Level sources have no storage and request service only while their input is high. Each source has its own enable bit, and a single global enable gates all of them.

The core tells the controller about instruction boundaries and about three global-enable operations: set, disable and return from handler. When an interrupt is accepted, the controller clears the global enable by itself. A return sets it again. After a return, one main-program instruction must retire before the next interrupt can be taken. A disable command blocks acceptance in the same cycle it arrives.

Software can clear event flags by writing ones to their bit positions.

Top module: `irq_prio_ctrl`

## Requirements
- R1: When `take_o` is high at a rising edge, the interrupt is accepted and `gie_o` reads 0 after that edge. `take_o` is never high in two consecutive cycles.
- R2: `sei_i` sets `gie_o` to 1 after the edge, including while a handler is running, so that nested interrupts can be taken.
- R3: `reti_i` sets `gie_o` to 1 after the edge, unless a disable command arrives in the same cycle.
- R4: Event source i (bit i of `evt_i`, 0 ≤ i < N_EVT) sets flag i (bit i of `flags_o`) after the edge. This happens whatever the per-source enable and the global enable are. The flag stays set until it is cleared as R5 describes.
- R5: Flag i clears after the edge in two cases: an accepted interrupt with `vec_o` = i, or a cycle with `wr_en_i` high and bit i of `wr_data_i` set. Bits written as zero leave their flags unchanged.
- R6: Level source j (bit j of `lvl_i`) is pending only in cycles where it is high and its enable is high. A level that drops before it is enabled is never served.
- R7: Source numbering runs as follows: event i has index i, and level j has index N_EVT+j. Among the sources that are pending and enabled, the lowest index wins. `vec_o` equals the winner's index while `take_o` is high.
- R8: After `reti_i`, the first cycle with `boundary_i` high never raises `take_o`. A later boundary may raise it.
- R9: `cli_i` forces `take_o` low in its own cycle and makes `gie_o` read 0 after the edge. This holds even when `sei_i` or `reti_i` arrives in the same cycle.
- R10: If an event and a write-one-to-clear hit the same flag in the same cycle, the flag stays set.
- R11: `take_o` is high only when all of these hold: `boundary_i` is high, the global enable is set, the post-return hold is clear, `cli_i` is low, and some source is pending and enabled (per-source enable is bit index of `en_i`).
- R12: Reset clears the global enable, all flags and the post-return hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | N_EVT | Event pulses, one per event source |
| lvl_i | input | N_LVL | Level conditions, one per level source |
| en_i | input | N_EVT+N_LVL | Per-source enable, indexed by source number |
| sei_i | input | 1 | Set global enable |
| cli_i | input | 1 | Disable command, clears global enable at once |
| reti_i | input | 1 | Return from handler |
| boundary_i | input | 1 | Core is at an instruction boundary |
| wr_en_i | input | 1 | Flag write strobe |
| wr_data_i | input | N_EVT | Ones clear the matching flags |
| take_o | output | 1 | Take-interrupt pulse |
| vec_o | output | $clog2(N_EVT+N_LVL) | Winning source index |
| gie_o | output | 1 | Global enable state |
| flags_o | output | N_EVT | Event flag state |

## Verification
Several ordering hazards are targeted.

A disable command that coincides with a boundary and a pending flag must suppress `take_o`. A design that checks the registered enable alone would vector anyway. A disable that coincides with a return, or with a set, must leave the global enable clear; getting this wrong reopens interrupts.

The first boundary after a return is probed with work pending. A design without the hold would enter the handler again with no main-program progress. A pending event at index 3 is raced against a level at index 4, so a wrong priority order or a mistaken offset in the index mapping shows up directly. A write-one-to-clear that lands together with a fresh event must keep the flag, or that event is lost.

A level source that is disabled and then dropped before being enabled must never be served.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [1:0] {
    GOP_KEEP  = 2'd0,
    GOP_CLEAR = 2'd1,
    GOP_SET   = 2'd2
  } gie_op_e;

  // Global-enable update: disable beats acceptance beats set/return.
  function automatic gie_op_e gie_resolve(input logic cli, input logic take,
                                          input logic sei, input logic reti);
    if (cli || take)  return GOP_CLEAR;
    if (sei || reti)  return GOP_SET;
    return GOP_KEEP;
  endfunction

  // Next hold state after a return: set by return, spent by one boundary.
  function automatic logic hold_next(input logic hold, input logic reti,
                                     input logic bnd);
    if (reti) return 1'b1;
    if (bnd)  return 1'b0;
    return hold;
  endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N_EVT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_i,
  input  logic             wr_en_i,
  input  logic [N_EVT-1:0] wr_data_i,
  input  logic [N_EVT-1:0] svc_clr_i,
  output logic [N_EVT-1:0] flags_o
);

  logic [N_EVT-1:0] flags_q;
  logic [N_EVT-1:0] sw_clr;
  logic [N_EVT-1:0] clr_mask;

  assign sw_clr   = wr_en_i ? wr_data_i : '0;
  assign clr_mask = sw_clr | svc_clr_i;

  // A new event overrides any clear of the same bit.
  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr_mask) | evt_i;
  end

  assign flags_o = flags_q;

  a_r4_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((flags_q & $past(evt_i)) == $past(evt_i)));

  a_r5_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> ((flags_q & $past(wr_data_i) & ~$past(evt_i)) == '0));

  a_r5_svc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (|svc_clr_i) |=> ((flags_q & $past(svc_clr_i) & ~$past(evt_i)) == '0));

  a_r4_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_q & ~$past(flags_q) & ~$past(evt_i)) == '0));

endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int N  = 8,
  parameter int VW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  grant_o,
  output logic [VW-1:0] idx_o,
  output logic          any_o
);

  // Scan from the top so the lowest set index is the last one written.
  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
        idx_o      = VW'(i);
      end
    end
  end

  assign any_o = |req_i;

  a_r7_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  a_r7_grant_is_request: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_o & ~req_i) == '0) && (any_o == (grant_o != '0)));

  a_r7_lower_idle: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> ((req_i & ((N'(1) << idx_o) - N'(1))) == '0));

endmodule

// File: rtl/irq_gie_ctrl.sv
module irq_gie_ctrl
  import irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sei_i,
  input  logic cli_i,
  input  logic reti_i,
  input  logic bnd_i,
  input  logic any_i,
  output logic take_o,
  output logic gie_o
);

  logic    gie_q;
  logic    hold_q;
  gie_op_e op;

  assign take_o = bnd_i && gie_q && !hold_q && !cli_i && any_i;
  assign op     = gie_resolve(cli_i, take_o, sei_i, reti_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      case (op)
        GOP_CLEAR: gie_q <= 1'b0;
        GOP_SET:   gie_q <= 1'b1;
        default:   gie_q <= gie_q;
      endcase
      hold_q <= hold_next(hold_q, reti_i, bnd_i);
    end
  end

  assign gie_o = gie_q;

  a_r1_take_drops_gie: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !gie_q);

  a_r1_take_single: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !take_o);

  a_r2_sei_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (sei_i && !cli_i && !take_o) |=> gie_q);

  a_r3_reti_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !cli_i && !take_o) |=> gie_q);

  a_r8_hold_after_reti: assert property (@(posedge clk) disable iff (!rst_n)
    reti_i |=> !take_o);

  a_r9_cli_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    cli_i |-> !take_o);

  a_r9_cli_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cli_i |=> !gie_q);

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int N_EVT = 4,
  parameter int N_LVL = 4,
  localparam int N    = N_EVT + N_LVL,
  localparam int VW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_i,
  input  logic [N_LVL-1:0] lvl_i,
  input  logic [N-1:0]     en_i,
  input  logic             sei_i,
  input  logic             cli_i,
  input  logic             reti_i,
  input  logic             boundary_i,
  input  logic             wr_en_i,
  input  logic [N_EVT-1:0] wr_data_i,
  output logic             take_o,
  output logic [VW-1:0]    vec_o,
  output logic             gie_o,
  output logic [N_EVT-1:0] flags_o
);

  logic [N_EVT-1:0] flags;
  logic [N-1:0]     pend;
  logic [N-1:0]     grant;
  logic [VW-1:0]    win_idx;
  logic             any_pend;
  logic             take;
  logic [N_EVT-1:0] svc_clr;

  // Events occupy the low indices, levels follow.
  assign pend    = {lvl_i & en_i[N-1:N_EVT], flags & en_i[N_EVT-1:0]};
  assign svc_clr = take ? grant[N_EVT-1:0] : '0;

  irq_flag_bank #(.N_EVT(N_EVT)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .svc_clr_i (svc_clr),
    .flags_o   (flags)
  );

  irq_prio_arb #(.N(N), .VW(VW)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (pend),
    .grant_o (grant),
    .idx_o   (win_idx),
    .any_o   (any_pend)
  );

  irq_gie_ctrl u_gie (
    .clk    (clk),
    .rst_n  (rst_n),
    .sei_i  (sei_i),
    .cli_i  (cli_i),
    .reti_i (reti_i),
    .bnd_i  (boundary_i),
    .any_i  (any_pend),
    .take_o (take),
    .gie_o  (gie_o)
  );

  assign take_o  = take;
  assign vec_o   = win_idx;
  assign flags_o = flags;

  a_r11_take_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (boundary_i && gie_o && pend[vec_o]));

  a_r6_level_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && (int'(vec_o) >= N_EVT)) |-> lvl_i[int'(vec_o) - N_EVT]);

endmodule

// File: tb/tb_irq_prio_ctrl.sv
`timescale 1ns/1ps
module tb_irq_prio_ctrl;

  typedef struct packed {
    logic [3:0] evt;
    logic [3:0] lvl;
    logic [7:0] en;
    logic       sei, cli, reti, bnd, wr;
    logic [3:0] wd;
    logic       xtake;
    logic [2:0] xvec;
    logic       xgie;
    logic [3:0] xflg;
  } vec_t;

  localparam int NV = 34;

  // evt lvl en sei cli reti bnd wr wd | take vec gie flags
  localparam vec_t VT [0:NV-1] = '{
    '{4'b0010,4'b0000,8'hFF,1'b0,1'b0,1'b0,1'b1,1'b0,4'h0, 1'b0,3'd0,1'b0,4'b0010}, // R4
    '{4'b0000,4'b0000,8'hFF,1'b1,1'b0,1'b0,1'b0,1'b0,4'h0, 1'b0,3'd0,1'b1,4'b0010}, // R2
    '{4'b0000,4'b0000,8'hFF,1'b0,1'b0,1'b0,1'b1,1'b0,4'h0, 1'b1,3'd1,1'b0,4'b0000}, // R1
    '{4'b1001,4'b0000,8'hFF,1'b0,1'b0,1'b0,1'b1,1'b0,4'h0, 1'b0,3'd0,1'b0,4'b1001}, // R11
    '{4'b0000,4'b0000,8'hFF,1'b1,1'b0,1'b0,1'b0,1'b0,4'h0, 1'b0,3'd0,1'b1,4'b1001}, // R2
    '{4'b0000,4'b0000,8'hFF,1'b0,1'b0,1'b0,1'b1,1'b0,4'h0, 1'b1,3'd0,1'b0,4'b1000}, // R7
    '{4'b0000,4'b0000,8'hFF,1'b1,1'b0,1'b0,1'b0,1'b0,4'h0, 1'b0,3'd0,1'b1,4'b1000}, // R2
    '{4'b0000,4'b0000,8'hFF,1'b0,1'b0,1'b0,1'b0,1'b0,4'h0, 1'b0,3'd0,1'b1,4'b1000}, // R11
    '{4'b0000,4'b0000,8'hFF,1'b0,1'b1,1'b0,1'b1,1'b0,4'h0, 1'b0,3'd0,1'b0,4'b1000}, // R9
    '{4'b0000,4'b0000,8'hFF,1'b0,1'b0,1'b1,1'b0,1'b0,4'h0, 1'b0,3'd0,1'b1,4'b1000}, // R3
    '{4'b0000,4'b0000,8'hFF,1'b0,1'b0,1'b0,1'b1,1'b0,4'h0, 1'b0,3'd0,1'b1,4'b1000}, // R8
    '{4'b0000,4'b0000,8'hFF,1'b0,1'b0,1'b0,1'b1,1'b0,4'h0, 1'b1,3'd3,1'b0,4'b0000}, // R8
    '{4'b0000,4'b0100,8'hFF,1'b1,1'b0,1'b0,1'b0,1'b0,4'h0, 1'b0,3'd0,1'b1,4'b0000}, // R6
    '{4'b0000,4'b0100,8'hFF,1'b0,1'b0,1'b0,1'b1,1'b0,4'h0, 1'b1,3'd6,1'b0,4'b0000}, // R7
    '{4'b0000,4'b0000,8'hFF,1'b1,1'b0,1'b0,1'b0,1'b0,4'h0, 1'b0,3'd0,1'b1,4'b0000}, // R2
    '{4'b0000,4'b0000,8'hFF,1'b0,1'b0,1'b0,1'b1,1'b0,4'h0, 1'b0,3'd0,1'b1,4'b0000}, // R6
    '{4'b0000,4'b0001,8'hEF,1'b0,1'b0,1'b0,1'b1,1'b0,4'h0, 1'b0,3'd0,1'b1,4'b0000}, // R11
    '{4'b0000,4'b0000,8'hFF,1'b0,1'b0,1'b0,1'b1,1'b0,4'h0, 1'b0,3'd0,1'b1,4'b0000}, // R6
    '{4'b0100,4'b0000,8'hFB,1'b0,1'b0,1'b0,1'b1,1'b0,4'h0, 1'b0,3'd0,1'b1,4'b0100}, // R4
    '{4'b0000,4'b0000,8'hFB,1'b0,1'b0,1'b0,1'b1,1'b0,4'h0, 1'b0,3'd0,1'b1,4'b0100}, // R4
    '{4'b0000,4'b0000,8'hFB,1'b0,1'b0,1'b0,1'b0,1'b1,4'b0100, 1'b0,3'd0,1'b1,4'b0000}, // R5
    '{4'b0010,4'b0000,8'hFB,1'b0,1'b0,1'b0,1'b0,1'b1,4'b0010, 1'b0,3'd0,1'b1,4'b0010}, // R10
    '{4'b0000,4'b0000,8'hFF,1'b0,1'b0,1'b0,1'b1,1'b0,4'h0, 1'b1,3'd1,1'b0,4'b0000}, // R5
    '{4'b1000,4'b0001,8'hFF,1'b0,1'b0,1'b0,1'b0,1'b0,4'h0, 1'b0,3'd0,1'b0,4'b1000}, // R4
    '{4'b0000,4'b0001,8'hFF,1'b1,1'b0,1'b0,1'b0,1'b0,4'h0, 1'b0,3'd0,1'b1,4'b1000}, // R2
    '{4'b0000,4'b0001,8'hFF,1'b0,1'b0,1'b0,1'b1,1'b0,4'h0, 1'b1,3'd3,1'b0,4'b0000}, // R7
    '{4'b0000,4'b0001,8'hFF,1'b0,1'b0,1'b1,1'b0,1'b0,4'h0, 1'b0,3'd0,1'b1,4'b0000}, // R3
    '{4'b0000,4'b0001,8'hFF,1'b0,1'b0,1'b0,1'b1,1'b0,4'h0, 1'b0,3'd0,1'b1,4'b0000}, // R8
    '{4'b0000,4'b0001,8'hFF,1'b0,1'b0,1'b0,1'b1,1'b0,4'h0, 1'b1,3'd4,1'b0,4'b0000}, // R7
    '{4'b0000,4'b0000,8'hFF,1'b0,1'b1,1'b1,1'b0,1'b0,4'h0, 1'b0,3'd0,1'b0,4'b0000}, // R9
    '{4'b0000,4'b0000,8'hFF,1'b1,1'b1,1'b0,1'b0,1'b0,4'h0, 1'b0,3'd0,1'b0,4'b0000}, // R9
    '{4'b0000,4'b0000,8'hFF,1'b1,1'b0,1'b0,1'b0,1'b0,4'h0, 1'b0,3'd0,1'b1,4'b0000}, // R2
    '{4'b0000,4'b0010,8'hFF,1'b0,1'b0,1'b0,1'b1,1'b0,4'h0, 1'b0,3'd0,1'b1,4'b0000}, // R8
    '{4'b0000,4'b0010,8'hFF,1'b0,1'b0,1'b0,1'b1,1'b0,4'h0, 1'b1,3'd5,1'b0,4'b0000}  // R7
  };

  localparam string TAG [0:NV-1] = '{
    "R4","R2","R1","R11","R2","R7","R2","R11","R9","R3","R8","R8",
    "R6","R7","R2","R6","R11","R6","R4","R4","R5","R10","R5","R4",
    "R2","R7","R3","R8","R7","R9","R9","R2","R8","R7"
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] evt = '0;
  logic [3:0] lvl = '0;
  logic [7:0] en = '0;
  logic       sei = 1'b0, cli = 1'b0, reti = 1'b0, bnd = 1'b0, wr = 1'b0;
  logic [3:0] wd = '0;
  logic       take;
  logic [2:0] vec;
  logic       gie;
  logic [3:0] flg;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  irq_prio_ctrl #(.N_EVT(4), .N_LVL(4)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt),
    .lvl_i      (lvl),
    .en_i       (en),
    .sei_i      (sei),
    .cli_i      (cli),
    .reti_i     (reti),
    .boundary_i (bnd),
    .wr_en_i    (wr),
    .wr_data_i  (wd),
    .take_o     (take),
    .vec_o      (vec),
    .gie_o      (gie),
    .flags_o    (flg)
  );

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    evt = v.evt; lvl = v.lvl; en = v.en;
    sei = v.sei; cli = v.cli; reti = v.reti; bnd = v.bnd;
    wr = v.wr; wd = v.wd;
  endtask

  task automatic idle();
    evt = '0; lvl = '0; sei = 1'b0; cli = 1'b0; reti = 1'b0;
    bnd = 1'b0; wr = 1'b0; wd = '0;
  endtask

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    en = 8'hFF;
    repeat (3) @(posedge clk);
    #5;
    // R12: reset state held while reset is low
    check("R12", "gie in reset", int'(gie), 0);
    check("R12", "flags in reset", int'(flg), 0);
    check("R12", "take in reset", int'(take), 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VT[i]);
      #5;
      check(TAG[i], $sformatf("take v%0d", i), int'(take), int'(VT[i].xtake));
      if (VT[i].xtake)
        check(TAG[i], $sformatf("vec v%0d", i), int'(vec), int'(VT[i].xvec));
      @(posedge clk);
      #5;
      check(TAG[i], $sformatf("gie v%0d", i), int'(gie), int'(VT[i].xgie));
      check(TAG[i], $sformatf("flags v%0d", i), int'(flg), int'(VT[i].xflg));
    end

    // R12: reset in mid-run clears live state
    @(negedge clk);
    idle();
    evt = 4'b0110; sei = 1'b1;
    @(negedge clk);
    idle();
    check("R12", "pre-reset flags", int'(flg), 6);
    check("R12", "pre-reset gie", int'(gie), 1);
    rst_n = 1'b0;
    @(negedge clk);
    check("R12", "flags after reset", int'(flg), 0);
    check("R12", "gie after reset", int'(gie), 0);
    rst_n = 1'b1;

    // R10 + R5: two flags set, one cleared by write while another event lands
    @(negedge clk);
    evt = 4'b0011;
    @(negedge clk);
    evt = 4'b0001; wr = 1'b1; wd = 4'b0011;
    @(negedge clk);
    idle();
    check("R10", "event beats clear", int'(flg), 1);

    // R12: hold cleared by reset; first boundary after sei may take
    sei = 1'b1;
    @(negedge clk);
    idle();
    bnd = 1'b1;
    #5;
    check("R12", "take after reset, no hold", int'(take), 1);
    check("R7", "vec after reset", int'(vec), 0);
    @(negedge clk);
    idle();
    check("R1", "gie after take", int'(gie), 0);
    check("R5", "flag after take", int'(flg), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule